// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request on the chip into one synchronous chip reset. The requests come from the external reset pin, power-on detection, brown-out detection, the watchdog, a software reset request, and stack overflow or underflow. A power-on or brown-out request holds the chip in reset until two start-up stages have run in sequence. The first stage counts a fixed number of pulses from a slow internal tick. The second stage then counts a fixed number of main-clock cycles. The other sources release the chip as soon as their request goes away.

A five-bit cause field records which event caused the most recent reset. Each bit is active-low. The event clears its bit, and software sets it again through a write strobe. The pin and brown-out requests are asynchronous, so each passes through a two-flop synchronizer. The watchdog, software and stack requests are synchronous pulses from the core. The power-on input clears the whole block asynchronously, and its release is synchronized. A bypass input can skip each start-up stage.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_n` is low, `chip_rst` is 1 and `flags` is 5'b11100 (bit 1 power-on = 0, bit 0 brown-out = 0, bits 4..2 = 1). After release, reset stays asserted through both start-up stages.
- R2: In the start-up sequence, `chip_rst` falls exactly 2^OST_BITS clock edges after the edge that samples the 2^PWRT_BITS-th `slow_tick` pulse. Fewer tick pulses never release the reset.
- R3: A brown-out request (`bor_req` high) is honoured when `bor_hw_en` or `bor_sw_en` is high. It holds reset, clears flag bit 0, and once `bor_req` falls it runs both start-up stages.
- R4: When both brown-out enables are low, `bor_req` has no effect on `chip_rst` or on flag bit 0.
- R5: With `ext_en` high and `lp_mode` low, `ext_rst_n` low raises `chip_rst` on the third clock edge (two synchronizer stages plus one state update). Reset falls on the third edge after the pin returns high, with no start-up stages and no flag change.
- R6: With `ext_en` low, `ext_rst_n` has no effect on `chip_rst` or `flags`.
- R7: An honoured pin reset while `lp_mode` is high clears flag bit 2 (power-down).
- R8: `wdt_to` clears flag bit 3 (timeout), and `sw_reset` clears flag bit 4 (reset instruction).
- R9: `wdt_to`, `sw_reset`, `stk_full` and `stk_under` raise `chip_rst` one edge after they are sampled and hold it for exactly as many cycles as the request is held. The stack requests change no flag.
- R10: `flag_wr` loads `flag_wdata` into `flags` on the next edge. When an event clears a bit in the same cycle, the clear wins for that bit.
- R11: `pwrt_bypass` skips the tick-counting stage. With `ost_bypass`, reset falls on the edge after the final tick. With both set, reset falls without any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Power-on detect, active low, asynchronous clear |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| ext_en | input | 1 | Honour the external pin |
| lp_mode | input | 1 | Core is in a low-power mode |
| bor_req | input | 1 | Brown-out detected, asynchronous |
| bor_hw_en | input | 1 | Brown-out enable from configuration |
| bor_sw_en | input | 1 | Brown-out enable from software |
| wdt_to | input | 1 | Watchdog timeout request |
| sw_reset | input | 1 | Software reset request |
| stk_full | input | 1 | Stack overflow request |
| stk_under | input | 1 | Stack underflow request |
| slow_tick | input | 1 | One-cycle pulse from the slow internal clock |
| pwrt_bypass | input | 1 | Skip the tick-counting stage |
| ost_bypass | input | 1 | Skip the clock-counting stage |
| flag_wr | input | 1 | Write strobe for the cause flags |
| flag_wdata | input | 5 | Value written to the cause flags |
| chip_rst | output | 1 | Synchronous chip reset, active high |
| flags | output | 5 | Cause flags, active low: 0 brown-out, 1 power-on, 2 power-down, 3 timeout, 4 reset instruction |

## Verification
Power-on and brown-out are tried with tick pulses at random spacing. Holding back the final tick shows that release depends on the tick count and not on elapsed time. Sampling around the last tick pins down the exact length of the clock-counting stage. The three bypass settings separate each stage's contribution to the release time. Random sequences of pulse sources with random hold lengths, pin resets and software writes show which flag each source touches. They also show that reset length follows the request length, and that the enables mask their sources completely.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_PWRT, ST_OST} seq_state_e;

  localparam int FLAG_W = 5;
  localparam int FB_BOR = 0;
  localparam int FB_POR = 1;
  localparam int FB_PD  = 2;
  localparam int FB_TO  = 3;
  localparam int FB_RI  = 4;
  localparam logic [FLAG_W-1:0] FLAGS_AT_POR = 5'b11100;

  // Per-bit clear mask built from the event strobes
  function automatic logic [FLAG_W-1:0] event_mask(input logic bor, input logic pd,
                                                   input logic to, input logic ri);
    logic [FLAG_W-1:0] m;
    m         = '0;
    m[FB_BOR] = bor;
    m[FB_PD]  = pd;
    m[FB_TO]  = to;
    m[FB_RI]  = ri;
    return m;
  endfunction

  // Software write first, event clears override per bit
  function automatic logic [FLAG_W-1:0] flag_next(input logic [FLAG_W-1:0] cur,
                                                  input logic wr,
                                                  input logic [FLAG_W-1:0] wdata,
                                                  input logic [FLAG_W-1:0] clr);
    return (wr ? wdata : cur) & ~clr;
  endfunction

  // Where the sequencer goes once all requests have gone away
  function automatic seq_state_e hold_exit(input logic need_startup);
    return need_startup ? ST_PWRT : ST_RUN;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[g] <= RST_VAL;
        else         stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  logic bypass,
  output logic expire
);
  logic [BITS-1:0] cnt_q;
  logic            at_last;

  assign at_last = &cnt_q;
  assign expire  = run & (bypass | (step & at_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
  import rstseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [FLAG_W-1:0] wdata,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= FLAGS_AT_POR;
    else        flags <= flag_next(flags, wr, wdata, clr_mask);
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int PWRT_BITS   = 11,
  parameter int OST_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       ext_en,
  input  logic       lp_mode,
  input  logic       bor_req,
  input  logic       bor_hw_en,
  input  logic       bor_sw_en,
  input  logic       wdt_to,
  input  logic       sw_reset,
  input  logic       stk_full,
  input  logic       stk_under,
  input  logic       slow_tick,
  input  logic       pwrt_bypass,
  input  logic       ost_bypass,
  input  logic       flag_wr,
  input  logic [4:0] flag_wdata,
  output logic       chip_rst,
  output logic [4:0] flags
);
  localparam int ASYNC_W = 2;

  logic               rst_n_sync;
  logic [ASYNC_W-1:0] async_s;
  logic               ext_n_s, bor_s;
  logic               req_ext, req_bor, req_level, req_pulse, req_any;
  logic               ev_bor, ev_pd, ev_to, ev_ri;
  logic [FLAG_W-1:0]  clr_mask;
  logic               pwrt_exp, ost_exp;
  seq_state_e         state_q, state_d;
  logic               need_q;

  // Power-on clear: asserts at once, releases on the clock
  rstseq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (1'b1),
    .q      (rst_n_sync)
  );

  // Asynchronous requests: pin (idle high) and brown-out (idle low)
  rstseq_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_req_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      ({ext_rst_n, bor_req}),
    .q      (async_s)
  );
  assign ext_n_s = async_s[1];
  assign bor_s   = async_s[0];

  // Request qualification
  assign req_ext   = ~ext_n_s & ext_en;
  assign req_bor   = bor_s & (bor_hw_en | bor_sw_en);
  assign req_level = req_ext | req_bor;
  assign req_pulse = wdt_to | sw_reset | stk_full | stk_under;
  assign req_any   = req_level | req_pulse;

  // Cause events
  assign ev_bor   = req_bor;
  assign ev_pd    = req_ext & lp_mode;
  assign ev_to    = wdt_to;
  assign ev_ri    = sw_reset;
  assign clr_mask = event_mask(ev_bor, ev_pd, ev_to, ev_ri);

  // Start-up stages
  rstseq_timer #(.BITS(PWRT_BITS)) u_pwrt (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .run    (state_q == ST_PWRT),
    .step   (slow_tick),
    .bypass (pwrt_bypass),
    .expire (pwrt_exp)
  );

  rstseq_timer #(.BITS(OST_BITS)) u_ost (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .run    (state_q == ST_OST),
    .step   (1'b1),
    .bypass (ost_bypass),
    .expire (ost_exp)
  );

  // Sequencer
  always_comb begin
    state_d = state_q;
    if (req_any) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: state_d = hold_exit(need_q);
        ST_PWRT: if (pwrt_exp) state_d = ST_OST;
        ST_OST:  if (ost_exp)  state_d = ST_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_PWRT;
      need_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (req_bor)                 need_q <= 1'b1;
      else if (ost_exp && !req_any) need_q <= 1'b0;
    end
  end

  assign chip_rst = (state_q != ST_RUN);

  rstseq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr       (flag_wr),
    .wdata    (flag_wdata),
    .clr_mask (clr_mask),
    .flags    (flags)
  );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chip_rst,
  input logic [4:0] flags,
  input logic       req_level,
  input logic       req_pulse,
  input logic       ev_bor,
  input logic       ev_pd,
  input logic       wdt_to,
  input logic       sw_reset,
  input logic       flag_wr,
  input logic [4:0] flag_wdata,
  input logic [4:0] clr_mask
);
  p_level_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_level |=> chip_rst);

  p_pulse_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> chip_rst);

  p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst) |-> (!$past(req_level) && !$past(req_pulse)));

  p_bor_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bor |=> !flags[0]);

  p_pd_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pd |=> !flags[2]);

  p_to_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to |=> !flags[3]);

  p_ri_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> !flags[4]);

  p_por_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(flag_wr));

  p_wr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && clr_mask == 5'b0) |=> (flags == $past(flag_wdata)));
endmodule

bind reset_sequencer rstseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .chip_rst   (chip_rst),
  .flags      (flags),
  .req_level  (req_level),
  .req_pulse  (req_pulse),
  .ev_bor     (ev_bor),
  .ev_pd      (ev_pd),
  .wdt_to     (wdt_to),
  .sw_reset   (sw_reset),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .clr_mask   (clr_mask)
);

// File: tb/reset_sequencer_tb.sv
`timescale 1ns/1ps
module reset_sequencer_tb;
  localparam int PB = 3;
  localparam int OB = 4;
  localparam int NTICK = 1 << PB;
  localparam int NOST  = 1 << OB;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, ext_en = 1'b0, lp_mode = 1'b0;
  logic bor_req = 1'b0, bor_hw_en = 1'b0, bor_sw_en = 1'b0;
  logic wdt_to = 1'b0, sw_reset = 1'b0, stk_full = 1'b0, stk_under = 1'b0;
  logic slow_tick = 1'b0, pwrt_bypass = 1'b0, ost_bypass = 1'b0;
  logic flag_wr = 1'b0;
  logic [4:0] flag_wdata = 5'b0;
  logic chip_rst;
  logic [4:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] exp_f;

  always #10 clk = ~clk;

  reset_sequencer #(.PWRT_BITS(PB), .OST_BITS(OB)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .ext_en(ext_en),
    .lp_mode(lp_mode), .bor_req(bor_req), .bor_hw_en(bor_hw_en),
    .bor_sw_en(bor_sw_en), .wdt_to(wdt_to), .sw_reset(sw_reset),
    .stk_full(stk_full), .stk_under(stk_under), .slow_tick(slow_tick),
    .pwrt_bypass(pwrt_bypass), .ost_bypass(ost_bypass), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .chip_rst(chip_rst), .flags(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_tick();
    nclk($urandom_range(0, 2));
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  // Full start-up: ticks minus one, hold check, last tick, exact clock count
  task automatic run_startup(input string req);
    nclk(5);
    chk({req, " held before ticks"}, 32'(chip_rst), 32'd1);
    for (int i = 0; i < NTICK - 1; i++) one_tick();
    nclk(NOST + 4);
    chk("R2 short of ticks keeps reset", 32'(chip_rst), 32'd1);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    nclk(NOST - 1);
    chk("R2 still held one edge before release", 32'(chip_rst), 32'd1);
    nclk(1);
    chk("R2 released after clock stage", 32'(chip_rst), 32'd0);
  endtask

  task automatic bor_pulse_level();
    bor_req = 1'b1;
    nclk(5);
    chk("R3 brown-out asserts reset", 32'(chip_rst), 32'd1);
    exp_f[0] = 1'b0;
    chk("R3 brown-out flag", 32'(flags), 32'(exp_f));
    bor_req = 1'b0;
  endtask

  // Synchronous pulse source held for len cycles: 0 wdt, 1 sw, 2 full, 3 under
  task automatic pulse_src(input int which, input int len);
    chk("R9 idle before pulse", 32'(chip_rst), 32'd0);
    case (which)
      0: wdt_to = 1'b1;
      1: sw_reset = 1'b1;
      2: stk_full = 1'b1;
      default: stk_under = 1'b1;
    endcase
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk("R9 reset follows pulse", 32'(chip_rst), 32'd1);
    end
    wdt_to = 1'b0; sw_reset = 1'b0; stk_full = 1'b0; stk_under = 1'b0;
    if (which == 0) exp_f[3] = 1'b0;
    if (which == 1) exp_f[4] = 1'b0;
    @(negedge clk);
    chk("R9 reset ends with pulse", 32'(chip_rst), 32'd0);
    chk("R8 R9 flags after pulse source", 32'(flags), 32'(exp_f));
  endtask

  task automatic ext_src(input logic lp);
    lp_mode = lp;
    ext_rst_n = 1'b0;
    nclk(2);
    chk("R5 no reset after two edges", 32'(chip_rst), 32'd0);
    nclk(1);
    chk("R5 reset on third edge", 32'(chip_rst), 32'd1);
    nclk($urandom_range(1, 4));
    ext_rst_n = 1'b1;
    nclk(2);
    chk("R5 held two edges after pin release", 32'(chip_rst), 32'd1);
    nclk(1);
    chk("R5 released on third edge", 32'(chip_rst), 32'd0);
    if (lp) exp_f[2] = 1'b0;
    chk("R5 R7 flags after pin reset", 32'(flags), 32'(exp_f));
    lp_mode = 1'b0;
  endtask

  task automatic sw_write(input logic [4:0] v);
    flag_wr = 1'b1;
    flag_wdata = v;
    @(negedge clk);
    flag_wr = 1'b0;
    exp_f = v;
    chk("R10 software write", 32'(flags), 32'(exp_f));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog expired, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 power-on
    nclk(3);
    chk("R1 reset during power-on", 32'(chip_rst), 32'd1);
    chk("R1 flags during power-on", 32'(flags), 32'h1C);
    exp_f = 5'b11100;
    por_n = 1'b1;
    run_startup("R1");
    chk("R1 flags after start-up", 32'(flags), 32'(exp_f));

    // R3 brown-out, hardware enable
    sw_write(5'b11111);
    bor_hw_en = 1'b1;
    bor_pulse_level();
    run_startup("R3");

    // R4 brown-out masked
    bor_hw_en = 1'b0;
    sw_write(5'b11111);
    bor_req = 1'b1;
    nclk(6);
    chk("R4 masked brown-out no reset", 32'(chip_rst), 32'd0);
    chk("R4 masked brown-out flag kept", 32'(flags), 32'(exp_f));
    bor_req = 1'b0;
    nclk(4);

    // R11 bypass variants via software brown-out enable (also R3)
    bor_sw_en = 1'b1;
    ost_bypass = 1'b1;
    bor_pulse_level();
    nclk(5);
    for (int i = 0; i < NTICK - 1; i++) one_tick();
    nclk(3);
    chk("R11 ost bypass still waits ticks", 32'(chip_rst), 32'd1);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    chk("R11 ost bypass held at tick edge", 32'(chip_rst), 32'd1);
    nclk(1);
    chk("R11 ost bypass release next edge", 32'(chip_rst), 32'd0);

    pwrt_bypass = 1'b1;
    bor_pulse_level();
    nclk(8);
    chk("R11 both bypass release without ticks", 32'(chip_rst), 32'd0);

    ost_bypass = 1'b0;
    bor_pulse_level();
    nclk(5);
    chk("R11 tick stage bypass still counts clocks", 32'(chip_rst), 32'd1);
    nclk(NOST + 4);
    chk("R11 tick stage bypass release", 32'(chip_rst), 32'd0);
    pwrt_bypass = 1'b0;
    bor_sw_en = 1'b0;

    // R6 pin masked
    ext_rst_n = 1'b0;
    nclk(6);
    chk("R6 masked pin no reset", 32'(chip_rst), 32'd0);
    chk("R6 masked pin flags kept", 32'(flags), 32'(exp_f));
    ext_rst_n = 1'b1;
    nclk(3);

    // R5 and R7 pin resets
    ext_en = 1'b1;
    sw_write(5'b11111);
    ext_src(1'b0);
    ext_src(1'b1);

    // R10 write colliding with watchdog clear
    flag_wr = 1'b1;
    flag_wdata = 5'b11111;
    wdt_to = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0;
    wdt_to = 1'b0;
    exp_f = 5'b10111;
    chk("R10 event clear beats write", 32'(flags), 32'(exp_f));
    nclk(2);

    // Random mix of sources and writes (R8 R9 R10 R5)
    for (int t = 0; t < 40; t++) begin
      int sel;
      sel = $urandom_range(0, 5);
      if (sel <= 3)      pulse_src(sel, $urandom_range(1, 4));
      else if (sel == 4) ext_src(1'($urandom_range(0, 1)));
      else               sw_write(5'($urandom));
      nclk($urandom_range(1, 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule